// File: doc/BRIEF.md
# Majority-Vote Multidrop Serial Receiver

This block turns an asynchronous serial line into bytes. A tick at sixteen times the bit rate drives it. Each bit is settled by a two-of-three vote over samples near the centre of the bit. A character is a low start bit, eight data bits sent least significant first, an optional ninth (wakeup) bit, an optional parity bit and a high stop bit. The block delivers each accepted byte with a one-cycle strobe. It keeps sticky error flags for parity, framing and packet CRC faults.

Blocks are counted from a length input, which is the number of data bytes minus one. With the CRC check selected, each block is followed by two check bytes. These are consumed and not delivered. In wakeup mode several receivers can share one line. A character whose ninth bit is 1 opens a block and is compared with this node's address. A matching node takes in the rest of the block. A node that does not match only passes characters whose ninth bit is 1. Buffering of the delivered bytes belongs to the surrounding logic, which reports through a pulse input that it has consumed a block.

Top module: `mvote_rx`

## Requirements
- R1: The block decides each bit from the line levels on the 8th, 9th and 10th tick after the start edge is seen, counted within that bit. The bit takes the value held by at least two of those samples, so a one-tick disturbance of the line cannot change a byte.
- R2: The start bit is decided by the same vote. If that vote reads high, the receiver produces no byte and hunts again for a falling edge.
- R3: Frame order on the line: one start bit (0), then eight data bits with bit 0 first. Next comes one wakeup bit, present only when `wake_en`=1. Then one parity bit, present only when `par_en`=1. Last comes one stop bit (1).
- R4: When `par_en`=1, the expected parity bit is the XOR of the eight data bits if `par_even`=1, and its inverse if `par_even`=0. On a mismatch `par_err` is set and stays set, and the byte is still delivered.
- R5: A stop bit that votes 0 sets `frame_err` and it stays set. The byte is still delivered.
- R6: The CRC check is active when `crc_en`=1 and `par_en`=0; parity takes priority when both are 1. After `blk_len`+1 data bytes, the next two characters are check bytes. They are not delivered. The check uses x^16+x^12+x^5+1 with a start value of 0xFFFF, data fed bit 7 first, and the high check byte first. If the register is not 0 after both check bytes, `crc_err` is set.
- R7: A pulse on `err_clr` clears `par_err`, `frame_err` and `crc_err` in the next cycle. A clear overrides an error raised in the same cycle.
- R8: With `wake_en`=1, every character whose ninth bit is 1 is delivered. It starts a new block as byte 0, and `wake_hold` becomes 1 when its data equals `node_addr` and 0 otherwise.
- R9: With `wake_en`=1, a character whose ninth bit is 0 is delivered when `wake_hold`=1 and dropped when `wake_hold`=0.
- R10: A pulse on `blk_read` clears `wake_hold` in the next cycle, and so does `wake_en`=0. `wake_mode` follows `wake_en` one cycle later and is not changed by `blk_read`.
- R11: `byte_vld` is high for exactly one cycle per delivered byte, with `byte_out` valid in that cycle. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| wake_en | input | 1 | Ninth-bit addressing mode |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| crc_en | input | 1 | Block check bytes present and checked |
| node_addr | input | 8 | Address this node answers to |
| blk_len | input | 6 | Data bytes per block minus one |
| err_clr | input | 1 | Pulse clearing the error flags |
| blk_read | input | 1 | Pulse: held block consumed, drop the match |
| byte_out | output | 8 | Delivered byte |
| byte_vld | output | 1 | One-cycle strobe for byte_out |
| par_err | output | 1 | Sticky parity fault |
| frame_err | output | 1 | Sticky stop-bit fault |
| crc_err | output | 1 | Sticky block check fault |
| wake_mode | output | 1 | Wakeup mode active |
| wake_hold | output | 1 | Address match currently held |

## Verification
Several rules are checked by assertions on every cycle. Leaving the hunt state only on a low line, the single-cycle strobes, and the bit index staying inside the frame are all covered this way. So are the clear pulses taking effect, check bytes never being delivered, and unmatched ninth-bit-0 characters being dropped. The bench scenarios are needed for the rest. They show the vote rejecting a one-tick glitch, a short low pulse being discarded as a false start, and the exact bytes and parity verdicts across all 256 data values in both parity senses. They also cover a CRC pass and a CRC fail over a real block, parity taking priority over CRC, and the sequence of address match, drop and release.

// File: rtl/mvote_rx_pkg.sv
package mvote_rx_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              ninth;
    logic              par_bad;
    logic              frm_bad;
  } rx_char_t;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input logic [CHAR_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = CHAR_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/mvote_rx_sync.sv
module mvote_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= {pipe_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/mvote_rx_bits.sv
module mvote_rx_bits
  import mvote_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     line,
  input  logic     wake_en,
  input  logic     par_en,
  input  logic     par_even,
  output logic     ch_vld,
  output rx_char_t ch
);
  localparam int unsigned PH_W   = $clog2(OVS);
  localparam int unsigned MID    = OVS / 2;
  localparam logic [PH_W-1:0] SMP_A = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] SMP_C = PH_W'(MID + 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(OVS - 1);
  localparam int unsigned IDX_W  = 4;

  logic              busy_q;
  logic [PH_W-1:0]   phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        smp_q;
  logic [CHAR_W-1:0] data_q;
  logic              ninth_q;
  logic              pbit_q;

  logic [IDX_W-1:0] idx_par, idx_stop;
  logic             vote, exp_par;

  always_comb begin
    idx_par  = IDX_W'(CHAR_W + 1) + IDX_W'(wake_en);
    idx_stop = idx_par + IDX_W'(par_en);
    vote     = (smp_q[1] & smp_q[0]) | (smp_q[1] & line) | (smp_q[0] & line);
    exp_par  = par_even ? (^data_q) : ~(^data_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      idx_q   <= '0;
      smp_q   <= '0;
      data_q  <= '0;
      ninth_q <= 1'b0;
      pbit_q  <= 1'b0;
      ch_vld  <= 1'b0;
      ch      <= '0;
    end else begin
      ch_vld <= 1'b0;
      if (tick) begin
        if (!busy_q) begin
          if (!line) begin
            busy_q  <= 1'b1;
            phase_q <= '0;
            idx_q   <= '0;
          end
        end else begin
          if (phase_q == PH_END) begin
            phase_q <= '0;
            idx_q   <= idx_q + 1'b1;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
          if (phase_q >= SMP_A && phase_q < SMP_C) smp_q <= {smp_q[0], line};
          if (phase_q == SMP_C) begin
            if (idx_q == '0) begin
              if (vote) busy_q <= 1'b0;
            end else if (idx_q <= IDX_W'(CHAR_W)) begin
              data_q <= {vote, data_q[CHAR_W-1:1]};
            end else if (wake_en && idx_q == IDX_W'(CHAR_W + 1)) begin
              ninth_q <= vote;
            end else if (par_en && idx_q == idx_par) begin
              pbit_q <= vote;
            end
            if (idx_q == idx_stop) begin
              busy_q     <= 1'b0;
              ch_vld     <= 1'b1;
              ch.data    <= data_q;
              ch.ninth   <= wake_en & ninth_q;
              ch.par_bad <= par_en & (pbit_q != exp_par);
              ch.frm_bad <= ~vote;
            end
          end
        end
      end
    end
  end

  AST_HUNT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && tick && line) |=> !busy_q);  // R2
  AST_CHAR_PULSE: assert property (@(posedge clk) disable iff (rst)
    ch_vld |=> !ch_vld);  // R11
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (idx_q <= idx_stop));  // R3
endmodule

// File: rtl/mvote_rx_pkt.sv
module mvote_rx_pkt
  import mvote_rx_pkg::*;
#(
  parameter int unsigned LEN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_vld,
  input  rx_char_t          ch,
  input  logic              wake_en,
  input  logic              par_en,
  input  logic              crc_en,
  input  logic [CHAR_W-1:0] node_addr,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic              err_clr,
  input  logic              blk_read,
  output logic [CHAR_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              par_err,
  output logic              frame_err,
  output logic              crc_err,
  output logic              wake_mode,
  output logic              wake_hold
);
  localparam int unsigned POS_W = LEN_W + 1;

  logic [POS_W-1:0] pos_q, b_pos, last_pos;
  logic [CRC_W-1:0] crc_q, b_crc, upd;
  logic             chk_q, b_chk;
  logic             crc_on, first, accept, is_chk;

  always_comb begin
    crc_on   = crc_en & ~par_en;
    first    = wake_en & ch.ninth;
    accept   = ~wake_en | ch.ninth | wake_hold;
    last_pos = {1'b0, blk_len};
    b_pos    = first ? '0 : pos_q;
    b_crc    = first ? CRC_SEED : crc_q;
    b_chk    = first ? 1'b0 : chk_q;
    is_chk   = crc_on & (b_pos == last_pos + 1'b1);
    upd      = crc_step(b_crc, ch.data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      crc_q     <= CRC_SEED;
      chk_q     <= 1'b0;
      byte_out  <= '0;
      byte_vld  <= 1'b0;
      par_err   <= 1'b0;
      frame_err <= 1'b0;
      crc_err   <= 1'b0;
      wake_mode <= 1'b0;
      wake_hold <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      wake_mode <= wake_en;
      if (ch_vld && accept) begin
        par_err   <= par_err | ch.par_bad;
        frame_err <= frame_err | ch.frm_bad;
        if (is_chk) begin
          if (b_chk) begin
            crc_err <= crc_err | (upd != '0);
            pos_q   <= '0;
            chk_q   <= 1'b0;
            crc_q   <= CRC_SEED;
          end else begin
            chk_q <= 1'b1;
            crc_q <= upd;
            pos_q <= b_pos;
          end
        end else begin
          byte_vld <= 1'b1;
          byte_out <= ch.data;
          chk_q    <= 1'b0;
          if (!crc_on && b_pos == last_pos) begin
            pos_q <= '0;
            crc_q <= CRC_SEED;
          end else begin
            pos_q <= b_pos + 1'b1;
            crc_q <= upd;
          end
        end
        if (first) wake_hold <= (ch.data == node_addr);
      end
      if (err_clr) begin
        par_err   <= 1'b0;
        frame_err <= 1'b0;
        crc_err   <= 1'b0;
      end
      if (blk_read || !wake_en) wake_hold <= 1'b0;
    end
  end

  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> (!par_err && !frame_err && !crc_err));  // R7
  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (rst)
    blk_read |=> !wake_hold);  // R10
  AST_CHK_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (ch_vld && is_chk) |=> !byte_vld);  // R6
  AST_DROP_UNMATCHED: assert property (@(posedge clk) disable iff (rst)
    (ch_vld && wake_en && !ch.ninth && !wake_hold) |=> !byte_vld);  // R9
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);  // R11
endmodule

// File: rtl/mvote_rx.sv
module mvote_rx
  import mvote_rx_pkg::*;
#(
  parameter int unsigned OVS      = 16,
  parameter int unsigned LEN_W    = 6,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              wake_en,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              crc_en,
  input  logic [CHAR_W-1:0] node_addr,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic              err_clr,
  input  logic              blk_read,
  output logic [CHAR_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              par_err,
  output logic              frame_err,
  output logic              crc_err,
  output logic              wake_mode,
  output logic              wake_hold
);
  logic     line_s;
  logic     ch_vld;
  rx_char_t ch;

  mvote_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  mvote_rx_bits #(.OVS(OVS)) u_bits (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_s),
    .wake_en(wake_en), .par_en(par_en), .par_even(par_even),
    .ch_vld(ch_vld), .ch(ch)
  );

  mvote_rx_pkt #(.LEN_W(LEN_W)) u_pkt (
    .clk(clk), .rst(rst), .ch_vld(ch_vld), .ch(ch),
    .wake_en(wake_en), .par_en(par_en), .crc_en(crc_en),
    .node_addr(node_addr), .blk_len(blk_len),
    .err_clr(err_clr), .blk_read(blk_read),
    .byte_out(byte_out), .byte_vld(byte_vld),
    .par_err(par_err), .frame_err(frame_err), .crc_err(crc_err),
    .wake_mode(wake_mode), .wake_hold(wake_hold)
  );
endmodule

// File: tb/mvote_rx_tb.sv
module mvote_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;

  logic clk = 0;
  logic rst = 1;
  logic tick16 = 1;
  logic rxd = 1;
  logic wake_en = 0, par_en = 0, par_even = 0, crc_en = 0;
  logic [7:0] node_addr = 8'h5A;
  logic [5:0] blk_len = 6'd0;
  logic err_clr = 0, blk_read = 0;
  logic [7:0] byte_out;
  logic byte_vld, par_err, frame_err, crc_err, wake_mode, wake_hold;

  int checks = 0, errors = 0, rx_n = 0;
  logic [7:0] got [0:15];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mvote_rx u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .wake_en(wake_en), .par_en(par_en), .par_even(par_even), .crc_en(crc_en),
    .node_addr(node_addr), .blk_len(blk_len), .err_clr(err_clr), .blk_read(blk_read),
    .byte_out(byte_out), .byte_vld(byte_vld), .par_err(par_err), .frame_err(frame_err),
    .crc_err(crc_err), .wake_mode(wake_mode), .wake_hold(wake_hold)
  );

  always @(negedge clk) if (!rst && byte_vld) begin
    got[rx_n % 16] = byte_out;
    rx_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // glitch_bit: data bit index to disturb for one clock at offset goff (-1: none)
  task automatic send(input logic [7:0] d, input bit hw, input logic w, input bit hp,
                      input logic p, input logic stopv, input int glitch_bit, input int goff);
    hold_line(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      if (i == glitch_bit) begin
        hold_line(d[i], goff);
        hold_line(~d[i], 1);
        hold_line(d[i], BIT_CLKS - goff - 1);
      end else hold_line(d[i], BIT_CLKS);
    end
    if (hw) hold_line(w, BIT_CLKS);
    if (hp) hold_line(p, BIT_CLKS);
    hold_line(stopv, BIT_CLKS);
    hold_line(1'b1, 6);
  endtask

  task automatic send8(input logic [7:0] d);
    send(d, 0, 0, 0, 0, 1, -1, 0);
  endtask

  task automatic sendw(input logic [7:0] d, input logic w);
    send(d, 1, w, 0, 0, 1, -1, 0);
  endtask

  function automatic logic [15:0] crc_of(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2);
    logic [23:0] s;
    logic [15:0] c;
    s = {b0, b1, b2};
    c = 16'hFFFF;
    for (int k = 23; k >= 0; k--) begin
      if (c[15] ^ s[k]) c = (c << 1) ^ 16'h1021;
      else              c = c << 1;
    end
    return c;
  endfunction

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1;
    @(negedge clk);
    s = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    logic [15:0] c;
    logic p;
    do_reset();
    // R11 reset state
    chk(byte_vld == 0 && par_err == 0 && frame_err == 0 && crc_err == 0 &&
        wake_mode == 0 && wake_hold == 0, "R11 reset", 0, 0);

    // R1 R3 R4: every data value, both parity senses
    par_en = 1;
    for (int v = 0; v < 256; v++) begin
      par_even = v[0];
      p = par_even ? ^v[7:0] : ~^v[7:0];
      base = rx_n;
      send(v[7:0], 0, 0, 1, p, 1, -1, 0);
      chk(rx_n == base + 1 && got[base % 16] == v[7:0], "R3 sweep", got[base % 16], v);
    end
    chk(par_err == 0 && frame_err == 0, "R4 no false parity", par_err, 0);

    // R4 wrong parity
    par_even = 1;
    base = rx_n;
    send(8'h96, 0, 0, 1, 1'b1, 1, -1, 0);
    chk(rx_n == base + 1 && got[base % 16] == 8'h96, "R4 bad parity delivered", got[base % 16], 8'h96);
    chk(par_err == 1, "R4 par_err set", par_err, 1);
    pulse(err_clr);
    chk(par_err == 0, "R7 clear parity", par_err, 0);

    // R5 framing
    par_en = 0;
    base = rx_n;
    send(8'hC3, 0, 0, 0, 0, 1'b0, -1, 0);
    repeat (40) @(negedge clk);
    chk(rx_n == base + 1 && got[base % 16] == 8'hC3, "R5 bad stop delivered", rx_n - base, 1);
    chk(frame_err == 1, "R5 frame_err set", frame_err, 1);
    pulse(err_clr);
    chk(frame_err == 0, "R7 clear frame", frame_err, 0);

    // R1 single-clock glitches inside and outside the sample window
    base = rx_n;
    send(8'hA5, 0, 0, 0, 0, 1, 3, 10);
    send(8'h3C, 0, 0, 0, 0, 1, 5, 11);
    send(8'h0F, 0, 0, 0, 0, 1, 0, 2);
    chk(rx_n == base + 3, "R1 glitch count", rx_n - base, 3);
    chk(got[base % 16] == 8'hA5, "R1 glitch a", got[base % 16], 8'hA5);
    chk(got[(base + 1) % 16] == 8'h3C, "R1 glitch b", got[(base + 1) % 16], 8'h3C);
    chk(got[(base + 2) % 16] == 8'h0F, "R1 glitch c", got[(base + 2) % 16], 8'h0F);

    // R2 false start
    base = rx_n;
    hold_line(1'b0, 4);
    hold_line(1'b1, 60);
    chk(rx_n == base, "R2 false start no byte", rx_n - base, 0);
    send8(8'h5E);
    chk(rx_n == base + 1 && got[base % 16] == 8'h5E, "R2 recovers", got[base % 16], 8'h5E);

    // R6 CRC pass
    do_reset();
    crc_en = 1; blk_len = 6'd2;
    c = crc_of(8'h31, 8'h32, 8'h33);
    base = rx_n;
    send8(8'h31); send8(8'h32); send8(8'h33); send8(c[15:8]); send8(c[7:0]);
    chk(rx_n == base + 3, "R6 check bytes hidden", rx_n - base, 3);
    chk(got[(base + 2) % 16] == 8'h33, "R6 last data", got[(base + 2) % 16], 8'h33);
    chk(crc_err == 0, "R6 good crc", crc_err, 0);
    // R6 CRC fail
    base = rx_n;
    send8(8'h31); send8(8'h32); send8(8'h33); send8(c[15:8]); send8(c[7:0] ^ 8'h01);
    chk(rx_n == base + 3, "R6 fail count", rx_n - base, 3);
    chk(crc_err == 1, "R6 bad crc", crc_err, 1);
    pulse(err_clr);
    chk(crc_err == 0, "R7 clear crc", crc_err, 0);

    // R6 parity has priority over CRC
    do_reset();
    par_en = 1; par_even = 1; blk_len = 6'd0;
    base = rx_n;
    send(8'h11, 0, 0, 1, 1'b0, 1, -1, 0);
    send(8'h22, 0, 0, 1, 1'b0, 1, -1, 0);
    send(8'h33, 0, 0, 1, 1'b0, 1, -1, 0);
    chk(rx_n == base + 3, "R6 parity priority", rx_n - base, 3);
    chk(crc_err == 0 && par_err == 0, "R6 no crc with parity", crc_err, 0);

    // R8 R9 R10 wakeup addressing
    do_reset();
    par_en = 0; crc_en = 0; wake_en = 1; blk_len = 6'd1; node_addr = 8'h5A;
    @(negedge clk);
    chk(wake_mode == 1, "R10 wake_mode", wake_mode, 1);
    base = rx_n;
    sendw(8'h33, 1);
    chk(rx_n == base + 1 && got[base % 16] == 8'h33, "R8 other address delivered", got[base % 16], 8'h33);
    chk(wake_hold == 0, "R8 no match", wake_hold, 0);
    sendw(8'h11, 0);
    chk(rx_n == base + 1, "R9 unmatched dropped", rx_n - base, 1);
    sendw(8'h5A, 1);
    chk(wake_hold == 1, "R8 match held", wake_hold, 1);
    sendw(8'h22, 0);
    sendw(8'h44, 0);
    chk(rx_n == base + 4, "R9 matched accepted", rx_n - base, 4);
    chk(got[(base + 2) % 16] == 8'h22 && got[(base + 3) % 16] == 8'h44, "R9 matched data",
        got[(base + 3) % 16], 8'h44);
    pulse(blk_read);
    chk(wake_hold == 0 && wake_mode == 1, "R10 released", wake_hold, 0);
    sendw(8'h66, 0);
    chk(rx_n == base + 4, "R10 dropped after release", rx_n - base, 4);
    wake_en = 0;
    repeat (2) @(negedge clk);
    chk(wake_mode == 0, "R10 mode off", wake_mode, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule